// File: doc/BRIEF.md
# Sized Integer ALU with Condition Flags

This block is the integer execution unit of a small processor datapath. It takes a source operand and a destination operand, an operation code and an operand size: 8, 16 or 32 bits. It computes the result from the low-order bits that the size selects. The value it returns for write-back keeps the destination's bits above the operand size untouched. Add, subtract, compare, AND, OR, exclusive-OR, complement, test and clear are supported.

A five-bit condition flag register (extend, negative, zero, overflow, carry) sits beside the combinational datapath. It is loaded on a clock edge whenever the operation strobe is high. Each operation has its own flag rule. Some flags come from the result, some are forced to a constant, and the extend flag is either loaded from the carry or kept. Compare and test only touch flags, and they tell the surrounding datapath not to write a result.

Top module: `sized_cc_alu`

## Requirements
- R1: `size_i` selects the operand width: 0 is 8 bits, 1 is 16 bits, 2 and 3 are 32 bits. Only that many low bits of each operand take part. When `wb_o` is 1, bits of `res_o` above the width equal the same bits of `dst_i`.
- R2: Opcode 0 (add) gives the sized `dst_i + src_i`. C is the carry out of the top sized bit, X equals C, and V is signed overflow at the width.
- R3: Opcode 1 (subtract) gives the sized `dst_i - src_i`. C is the borrow (set when the sized source exceeds the sized destination unsigned), X equals C, and V is signed overflow at the width.
- R4: Opcode 2 (compare) sets N, Z, V and C exactly as subtract would. X is kept. `wb_o` is 0 and `res_o` equals `dst_i`.
- R5: Opcodes 3, 4 and 5 (AND, OR, exclusive-OR of `src_i` and `dst_i`) set N and Z from the sized result. They clear V and C and keep X.
- R6: Opcode 6 (complement) returns the sized bitwise inverse of `dst_i`. It uses the same flag rule as R5.
- R7: Opcode 7 (test) sets N and Z from the sized `dst_i`. It clears V and C, keeps X, drives `wb_o` to 0 and returns `res_o` equal to `dst_i`.
- R8: Opcode 8 (clear) returns zero in the sized bits. It sets N=0, Z=1, V=0 and C=0 and keeps X.
- R9: N is the top bit of the sized result. Z is 1 only when every sized result bit is 0.
- R10: `ccr_o` is {X,N,Z,V,C} from bit 4 down to bit 0. It is all zeros after a synchronous reset. It changes only on a clock edge where `valid_i` is 1, and otherwise holds.
- R11: Opcodes 9 to 15 do nothing. `wb_o` is 0, `res_o` equals `dst_i`, and `ccr_o` keeps its value even when `valid_i` is 1.
- R12: `wb_o` is 1 for opcodes 0, 1, 3, 4, 5, 6 and 8, and 0 for all others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Operation strobe; loads the flag register |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand width select |
| src_i | input | 32 | Source operand |
| dst_i | input | 32 | Destination operand |
| res_o | output | 32 | Merged write-back value (combinational) |
| wb_o | output | 1 | Result should be written to the destination |
| ccr_o | output | 5 | Registered flags {X,N,Z,V,C} |

## Verification
Add and subtract are driven at every width with operand pairs chosen to separate the cases. Some pairs carry out of only the selected width, some overflow signed without carrying, and some give an exactly zero result. Together these show whether carry, overflow and zero are taken from the right bit position. The destination's upper bits are filled with a non-zero pattern so that any leak of upper-bit arithmetic into the merged value shows up. Logic, compare and test operations are run after a carry has set X, which shows whether each operation keeps X or overwrites it. Idle cycles and undefined opcodes follow flag-setting operations, which shows whether the register holds.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = 3;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_CMP = 4'd2,
        OP_AND = 4'd3,
        OP_OR  = 4'd4,
        OP_XOR = 4'd5,
        OP_NOT = 4'd6,
        OP_TST = 4'd7,
        OP_CLR = 4'd8
    } alu_op_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    // Width in bits of lane i (8, 16, 32, ...)
    function automatic int lane_w(input int i);
        return 8 << i;
    endfunction

    // Lane index chosen by the size code; codes past the widest lane saturate
    function automatic int lane_of(input logic [1:0] sz);
        return (int'(sz) >= LANES) ? LANES - 1 : int'(sz);
    endfunction

    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
        return {DATA_W{1'b1}} >> (DATA_W - lane_w(lane_of(sz)));
    endfunction

    function automatic logic op_writes(input alu_op_e op);
        case (op)
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOT, OP_CLR: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cc_arith_lanes.sv
module cc_arith_lanes
    import cc_alu_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N = LANES
) (
    input  logic                 sub_i,
    input  logic [W-1:0]         src_i,
    input  logic [W-1:0]         dst_i,
    output logic [N-1:0][W-1:0]  sum_o,
    output logic [N-1:0]         carry_o,
    output logic [N-1:0]         ovf_o
);

    for (genvar i = 0; i < N; i++) begin : g_lane
        localparam int LW = lane_w(i);
        logic [LW-1:0] a;
        logic [LW-1:0] b;
        logic [LW:0]   ext;
        logic [W-1:0]  wide;

        assign a   = src_i[LW-1:0];
        assign b   = dst_i[LW-1:0];
        assign ext = sub_i ? ({1'b0, b} - {1'b0, a}) : ({1'b0, b} + {1'b0, a});

        always_comb begin
            wide         = '0;
            wide[LW-1:0] = ext[LW-1:0];
        end

        assign sum_o[i]   = wide;
        assign carry_o[i] = ext[LW];
        assign ovf_o[i]   = sub_i
            ? ((a[LW-1] != b[LW-1]) && (ext[LW-1] != b[LW-1]))
            : ((a[LW-1] == b[LW-1]) && (ext[LW-1] != a[LW-1]));
    end

endmodule

// File: rtl/cc_result_mux.sv
module cc_result_mux
    import cc_alu_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N = LANES
) (
    input  alu_op_e              op_i,
    input  logic [1:0]           size_i,
    input  logic [W-1:0]         src_i,
    input  logic [W-1:0]         dst_i,
    input  logic [N-1:0][W-1:0]  sum_i,
    input  logic [N-1:0]         carry_i,
    input  logic [N-1:0]         ovf_i,
    output logic [W-1:0]         res_o,
    output logic                 wb_o,
    output logic                 neg_o,
    output logic                 zero_o,
    output logic                 carry_o,
    output logic                 ovf_o
);

    int            lane;
    logic [W-1:0]  mask;
    logic [W-1:0]  raw;
    logic [W-1:0]  sized;

    always_comb begin
        lane = lane_of(size_i);
        mask = size_mask(size_i);
        case (op_i)
            OP_ADD, OP_SUB, OP_CMP: raw = sum_i[lane];
            OP_AND:                 raw = src_i & dst_i;
            OP_OR:                  raw = src_i | dst_i;
            OP_XOR:                 raw = src_i ^ dst_i;
            OP_NOT:                 raw = ~dst_i;
            OP_TST:                 raw = dst_i;
            default:                raw = '0;
        endcase
        sized   = raw & mask;
        neg_o   = sized[lane_w(lane) - 1];
        zero_o  = (sized == '0);
        carry_o = carry_i[lane];
        ovf_o   = ovf_i[lane];
        wb_o    = op_writes(op_i);
        res_o   = wb_o ? ((dst_i & ~mask) | sized) : dst_i;
    end

endmodule

// File: rtl/cc_flag_rules.sv
module cc_flag_rules
    import cc_alu_pkg::*;
(
    input  alu_op_e op_i,
    input  ccr_t    cur_i,
    input  logic    neg_i,
    input  logic    zero_i,
    input  logic    carry_i,
    input  logic    ovf_i,
    output ccr_t    next_o
);

    always_comb begin
        next_o = cur_i;
        case (op_i)
            OP_ADD, OP_SUB: next_o = '{x: carry_i, n: neg_i, z: zero_i, v: ovf_i, c: carry_i};
            OP_CMP:         next_o = '{x: cur_i.x, n: neg_i, z: zero_i, v: ovf_i, c: carry_i};
            OP_AND, OP_OR, OP_XOR, OP_NOT, OP_TST:
                            next_o = '{x: cur_i.x, n: neg_i, z: zero_i, v: 1'b0, c: 1'b0};
            OP_CLR:         next_o = '{x: cur_i.x, n: 1'b0, z: 1'b1, v: 1'b0, c: 1'b0};
            default:        next_o = cur_i;
        endcase
    end

endmodule

// File: rtl/sized_cc_alu.sv
module sized_cc_alu
    import cc_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [3:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    output logic [DATA_W-1:0] res_o,
    output logic              wb_o,
    output logic [4:0]        ccr_o
);

    alu_op_e                     op;
    logic                        is_sub;
    logic [LANES-1:0][DATA_W-1:0] lane_sum;
    logic [LANES-1:0]            lane_carry;
    logic [LANES-1:0]            lane_ovf;
    logic                        neg, zero, carry, ovf;
    ccr_t                        ccr_q, ccr_d;

    assign op     = alu_op_e'(op_i);
    assign is_sub = (op == OP_SUB) || (op == OP_CMP);

    cc_arith_lanes #(.W(DATA_W), .N(LANES)) u_lanes (
        .sub_i   (is_sub),
        .src_i   (src_i),
        .dst_i   (dst_i),
        .sum_o   (lane_sum),
        .carry_o (lane_carry),
        .ovf_o   (lane_ovf)
    );

    cc_result_mux #(.W(DATA_W), .N(LANES)) u_mux (
        .op_i    (op),
        .size_i  (size_i),
        .src_i   (src_i),
        .dst_i   (dst_i),
        .sum_i   (lane_sum),
        .carry_i (lane_carry),
        .ovf_i   (lane_ovf),
        .res_o   (res_o),
        .wb_o    (wb_o),
        .neg_o   (neg),
        .zero_o  (zero),
        .carry_o (carry),
        .ovf_o   (ovf)
    );

    cc_flag_rules u_flags (
        .op_i    (op),
        .cur_i   (ccr_q),
        .neg_i   (neg),
        .zero_i  (zero),
        .carry_i (carry),
        .ovf_i   (ovf),
        .next_o  (ccr_d)
    );

    always_ff @(posedge clk) begin
        if (rst)          ccr_q <= '0;
        else if (valid_i) ccr_q <= ccr_d;
    end

    assign ccr_o = ccr_q;

endmodule

// File: rtl/cc_alu_checker.sv
module cc_alu_checker (
    input logic        clk,
    input logic        rst,
    input logic        valid_i,
    input logic [3:0]  op_i,
    input logic [1:0]  size_i,
    input logic [31:0] dst_i,
    input logic [31:0] res_o,
    input logic        wb_o,
    input logic [4:0]  ccr_o
);

    p_reset_zero_r10: assert property (@(posedge clk) rst |=> ccr_o == 5'b0);

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(ccr_o));

    p_upper_byte_r1: assert property (@(posedge clk) disable iff (rst)
        (wb_o && size_i == 2'd0) |-> res_o[31:8] == dst_i[31:8]);

    p_upper_word_r1: assert property (@(posedge clk) disable iff (rst)
        (wb_o && size_i == 2'd1) |-> res_o[31:16] == dst_i[31:16]);

    p_x_tracks_c_r2: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 4'd0) |=> ccr_o[4] == ccr_o[0]);

    p_x_tracks_b_r3: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 4'd1) |=> ccr_o[4] == ccr_o[0]);

    p_cmp_nowrite_r4: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd2) |-> (!wb_o && res_o == dst_i));

    p_cmp_keeps_x_r4: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 4'd2) |=> ccr_o[4] == $past(ccr_o[4]));

    p_logic_flags_r5: assert property (@(posedge clk) disable iff (rst)
        (valid_i && (op_i == 4'd3 || op_i == 4'd4 || op_i == 4'd5))
        |=> (ccr_o[1:0] == 2'b00 && ccr_o[4] == $past(ccr_o[4])));

    p_not_flags_r6: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 4'd6) |=> (ccr_o[1:0] == 2'b00 && ccr_o[4] == $past(ccr_o[4])));

    p_tst_nowrite_r7: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd7) |-> (!wb_o && res_o == dst_i));

    p_clr_flags_r8: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 4'd8) |=> (ccr_o[3:0] == 4'b0100 && ccr_o[4] == $past(ccr_o[4])));

    p_zero_long_r9: assert property (@(posedge clk) disable iff (rst)
        (valid_i && wb_o && size_i[1] && op_i != 4'd8)
        |=> ccr_o[2] == ($past(res_o) == 32'd0));

    p_undef_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i > 4'd8) |=> $stable(ccr_o));

    p_undef_nowrite_r12: assert property (@(posedge clk) disable iff (rst)
        (op_i > 4'd8) |-> (!wb_o && res_o == dst_i));

endmodule

bind sized_cc_alu cc_alu_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .valid_i (valid_i),
    .op_i    (op_i),
    .size_i  (size_i),
    .dst_i   (dst_i),
    .res_o   (res_o),
    .wb_o    (wb_o),
    .ccr_o   (ccr_o)
);

// File: tb/sim_sized_cc_alu.sv
`timescale 1ns/100ps
module sim_sized_cc_alu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic [1:0]  size_i = 2'd0;
    logic [31:0] src_i = '0;
    logic [31:0] dst_i = '0;
    logic [31:0] res_o;
    logic        wb_o;
    logic [4:0]  ccr_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        logic [31:0] res;
        logic        wb;
        logic [4:0]  ccr;
        string       tag;
    } exp_t;

    exp_t       q[$];
    logic [4:0] model_ccr = 5'b0;

    always #2.5 clk = ~clk;

    sized_cc_alu u0 (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .size_i(size_i),
        .src_i(src_i), .dst_i(dst_i), .res_o(res_o), .wb_o(wb_o), .ccr_o(ccr_o)
    );

    function automatic exp_t predict(input logic [3:0] o, input logic [1:0] s,
                                     input logic [31:0] sv, input logic [31:0] dv,
                                     input logic [4:0] cur);
        exp_t e;
        int w;
        logic [31:0] m, a, b, r;
        logic [63:0] t;
        logic x, n, z, v, c, writes;
        w = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
        m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        a = sv & m;
        b = dv & m;
        {x, n, z, v, c} = cur;
        writes = 1'b1;
        r = '0;
        case (o)
            4'd0: begin
                t = {32'd0, b} + {32'd0, a};
                r = t[31:0] & m;
                c = t[w];
                v = (a[w-1] == b[w-1]) && (r[w-1] != a[w-1]);
                x = c;
            end
            4'd1, 4'd2: begin
                t = {32'd0, b} - {32'd0, a};
                r = t[31:0] & m;
                c = (a > b);
                v = (a[w-1] != b[w-1]) && (r[w-1] != b[w-1]);
                if (o == 4'd1) x = c;
                writes = (o == 4'd1);
            end
            4'd3: r = a & b;
            4'd4: r = a | b;
            4'd5: r = a ^ b;
            4'd6: r = ~b & m;
            4'd7: begin r = b; writes = 1'b0; end
            4'd8: r = '0;
            default: writes = 1'b0;
        endcase
        if (o <= 4'd8) begin
            n = r[w-1];
            z = (r == 0);
            if (o >= 4'd3) begin v = 1'b0; c = 1'b0; end
        end
        e.res = writes ? ((dv & ~m) | r) : dv;
        e.wb  = writes;
        e.ccr = {x, n, z, v, c};
        return e;
    endfunction

    task automatic drive(input logic v, input logic [3:0] o, input logic [1:0] s,
                         input logic [31:0] sv, input logic [31:0] dv, input string tag);
        exp_t e;
        @(negedge clk);
        valid_i = v; op_i = o; size_i = s; src_i = sv; dst_i = dv;
        e = predict(o, s, sv, dv, model_ccr);
        if (!v) e.ccr = model_ccr;
        model_ccr = e.ccr;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare each scoreboard item one step after the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, "res", res_o, e.res);
                check(e.tag, "wb", {31'd0, wb_o}, {31'd0, e.wb});
                check(e.tag, "ccr", {27'd0, ccr_o}, {27'd0, e.ccr});
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10", "reset ccr", {27'd0, ccr_o}, 32'd0);

        // R2/R1: byte add, upper bits of destination preserved
        drive(1, 4'd0, 2'd0, 32'h0000_001D, 32'hAABB_CC0E, "R1 R2 byte add");
        // R2: byte carry to zero: Z, C, X
        drive(1, 4'd0, 2'd0, 32'h0000_0001, 32'h1234_56FF, "R2 R9 byte carry");
        // R5: logic keeps X (set above), clears C
        drive(1, 4'd3, 2'd0, 32'h0000_001D, 32'hFFFF_FF0E, "R5 and byte");
        drive(1, 4'd4, 2'd1, 32'h0000_8001, 32'h5555_0100, "R5 or word");
        drive(1, 4'd5, 2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 xor long zero");
        // R2: word signed overflow without carry
        drive(1, 4'd0, 2'd1, 32'h0000_0001, 32'hDEAD_7FFF, "R2 word ovf");
        // R2: long add with carry out
        drive(1, 4'd0, 2'd2, 32'h8000_0000, 32'h8000_0000, "R2 long carry ovf");
        // R3: byte borrow
        drive(1, 4'd1, 2'd0, 32'h0000_0001, 32'h7777_7700, "R3 byte borrow");
        // R3: long signed overflow
        drive(1, 4'd1, 2'd2, 32'h0000_0001, 32'h8000_0000, "R3 long ovf");
        // R3: word equal to zero, no borrow
        drive(1, 4'd1, 2'd1, 32'h0000_1234, 32'hFFFF_1234, "R3 word zero");
        // R4: compare with borrow, X stays
        drive(1, 4'd0, 2'd0, 32'h0000_00FF, 32'h0000_00FF, "R2 set X");
        drive(1, 4'd2, 2'd1, 32'h0000_0005, 32'h0000_0003, "R4 cmp borrow");
        drive(1, 4'd2, 2'd2, 32'h0000_0009, 32'h0000_0009, "R4 cmp equal");
        // R6: complement word
        drive(1, 4'd6, 2'd1, 32'h0000_0000, 32'hCAFE_00F0, "R6 not word");
        // R7: test long negative, byte zero
        drive(1, 4'd7, 2'd2, 32'h0000_0000, 32'h8000_0001, "R7 tst long neg");
        drive(1, 4'd7, 2'd0, 32'h0000_0000, 32'h1234_5600, "R7 tst byte zero");
        // R8: clear byte, X kept
        drive(1, 4'd0, 2'd0, 32'h0000_0080, 32'h0000_0080, "R2 set X again");
        drive(1, 4'd8, 2'd0, 32'h0000_0000, 32'hABCD_EF99, "R8 clr byte");
        drive(1, 4'd8, 2'd2, 32'h0000_0000, 32'hABCD_EF99, "R8 clr long");
        // R10: strobe low, flags hold across a flag-changing op
        drive(0, 4'd0, 2'd0, 32'h0000_0001, 32'h0000_00FF, "R10 idle add");
        drive(0, 4'd6, 2'd2, 32'h0000_0000, 32'h0000_0000, "R10 idle not");
        // R11/R12: undefined opcodes
        drive(1, 4'd9,  2'd0, 32'h0000_0001, 32'h0102_0304, "R11 undef 9");
        drive(1, 4'd15, 2'd2, 32'hFFFF_FFFF, 32'h0000_0000, "R11 R12 undef 15");
        // R1: size code 3 acts as long
        drive(1, 4'd0, 2'd3, 32'h0001_0000, 32'h0001_0000, "R1 size3 long");

        drive(0, 4'd15, 2'd0, 32'h0, 32'h0, "R10 tail");
        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule